// File: doc/BRIEF.md
# Dual-Rail Shared-Inductor Switch Sequencer

This block is the digital heart of a step-down regulator in which one inductor feeds two output rails in turn. Analog comparators outside the block report, for each rail, whether it has dropped under its lower bound or risen over its upper bound. They also report which rail carries the larger voltage error and whether current in the inductor is about to reverse. From these flags the sequencer drives five switch enables: the battery-side high switch, the ground-side low switch, one select switch per rail, and a shorting switch that clamps the inductor.

Two loops run side by side. The rail selector connects the inductor to whichever rail has dropped low. When both rails are low, the priority flag settles the choice. The bridge loop applies hysteretic control to the rail now being served: the high switch turns on when that rail is low, and the low switch turns on when it is high. Both loops insert a programmable break-before-make gap when they change over. A reverse-current flag overrides both loops and parks the inductor grounded. When the flag drops, the block restarts from an all-off cycle.

Every comparator flag is asynchronous and passes through a two-flop synchroniser before the logic uses it.

Top module: `dual_rail_inductor_seq`

## Requirements
- R1: While reset is held, and until the first edge after reset is released, the outputs are low switch and short switch on, with high switch and both selects off.
- R2: A flag held steady from before rising edge k first changes the outputs just after edge k+2, and not earlier.
- R3: While the synchronised reverse flag is high, the outputs are low switch and short switch on, with high switch and both selects off. This holds whatever the other flags do.
- R4: After the reverse flag clears, there is exactly one cycle with all five switches off. On the next edge the selector evaluates the flags, and on the edge after that the bridge evaluates them.
- R5: When no rail is selected and only rail A is low, rail A is selected with no gap.
- R6: While rail A is served, rail B going low with rail A not low moves the selection to rail B.
- R7: When both rails are low, the priority input picks the rail: 1 selects B and 0 selects A. This applies both from idle and while the other rail is served.
- R8: When no rail is low, the selection holds its present value.
- R9: A change of selection between the two rails puts both selects off for exactly D cycles, where D = max(1, dead_cfg).
- R10: When the served rail is high, the high switch turns off and the low switch turns on. When the served rail is low, the low switch turns off and the high switch turns on.
- R11: Each high/low changeover puts both switches off for exactly D cycles. The high and low switches are never on together.
- R12: The bridge reacts only to the flags of the selected rail. The unselected rail's upper-bound flag does not change the bridge state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_a_low | input | 1 | Rail A below its lower bound (asynchronous) |
| out_a_high | input | 1 | Rail A above its upper bound (asynchronous) |
| out_b_low | input | 1 | Rail B below its lower bound (asynchronous) |
| out_b_high | input | 1 | Rail B above its upper bound (asynchronous) |
| b_first | input | 1 | 1 when rail B has the larger error (asynchronous) |
| rev_flag | input | 1 | Reverse inductor current detected (asynchronous) |
| dead_cfg | input | DT_W | Break-before-make gap in cycles; 0 acts as 1 |
| hs_en | output | 1 | Battery-side high switch enable |
| ls_en | output | 1 | Ground-side low switch enable |
| sel_a_en | output | 1 | Rail A select switch enable |
| sel_b_en | output | 1 | Rail B select switch enable |
| short_en | output | 1 | Inductor shorting switch enable |

## Verification
The selector is swept over every combination of the two low flags and the priority flag, starting from idle, from rail A served and from rail B served. The expected rail is computed arithmetically, which separates the priority behaviour from the hold behaviour and from plain single requests. Bridge changeovers and selector changeovers are each timed cycle by cycle for gap settings of 0, 1, 3 and 7. This distinguishes an off-by-one in the gap from a missing gap, and the early and late samples pin the two-flop latency. The reverse-current sequence checks the standby pattern, the single all-off recovery cycle and the staggered restart of the two loops. A stray upper-bound flag on the idle rail shows that the bridge looks only at the served rail.

// File: rtl/dri_pkg.sv
package dri_pkg;

    // Bit positions of the synchronised flag vector
    localparam int FL_LO_A  = 0;
    localparam int FL_HI_A  = 1;
    localparam int FL_LO_B  = 2;
    localparam int FL_HI_B  = 3;
    localparam int FL_PRI_B = 4;
    localparam int FL_REV   = 5;
    localparam int FL_N     = 6;

    typedef enum logic [1:0] {RAIL_NONE, RAIL_A, RAIL_B, RAIL_GAP} rail_e;
    typedef enum logic [1:0] {BR_OFF, BR_HIGH, BR_LOW, BR_GAP} br_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } thr_t;

    // Rail wanted by the current requests; RAIL_NONE means keep what is held
    function automatic rail_e pick_rail(input logic req_a, input logic req_b,
                                        input logic b_first);
        if (req_a && req_b) return b_first ? RAIL_B : RAIL_A;
        if (req_a)          return RAIL_A;
        if (req_b)          return RAIL_B;
        return RAIL_NONE;
    endfunction

endpackage

// File: rtl/dri_sync.sv
module dri_sync #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    logic [N-1:0] meta_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[g] <= 1'b0;
                q_sync[g] <= 1'b0;
            end else begin
                meta_q[g] <= d_async[g];
                q_sync[g] <= meta_q[g];
            end
        end
    end
endmodule

// File: rtl/dri_arbiter.sv
module dri_arbiter #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            req_a,
    input  logic            req_b,
    input  logic            b_first,
    input  logic [DT_W-1:0] dead_eff,
    output logic            sel_a_o,
    output logic            sel_b_o
);
    import dri_pkg::*;

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    typedef struct packed {
        rail_e           cur;
        rail_e           pend;
        logic [DT_W-1:0] cnt;
    } arb_st_t;

    arb_st_t st_q, st_d;
    rail_e   want;

    always_comb begin
        st_d = st_q;
        want = pick_rail(req_a, req_b, b_first);
        unique case (st_q.cur)
            RAIL_NONE: if (want != RAIL_NONE) st_d.cur = want;
            RAIL_A, RAIL_B: begin
                if (want != RAIL_NONE && want != st_q.cur) begin
                    st_d.cur  = RAIL_GAP;
                    st_d.pend = want;
                    st_d.cnt  = dead_eff - ONE;
                end
            end
            default: begin
                if (st_q.cnt == '0) st_d.cur = st_q.pend;
                else                st_d.cnt = st_q.cnt - ONE;
            end
        endcase
        if (clr) st_d = '{RAIL_NONE, RAIL_NONE, '0};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{RAIL_NONE, RAIL_NONE, '0};
        else     st_q <= st_d;
    end

    assign sel_a_o = (st_q.cur == RAIL_A);
    assign sel_b_o = (st_q.cur == RAIL_B);

    // R9: a select never turns on in the cycle right after the other one was on
    assert_sel_b_bbm_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_b_o) |-> !$past(sel_a_o));
    assert_sel_a_bbm_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_a_o) |-> !$past(sel_b_o));
endmodule

// File: rtl/dri_bridge.sv
module dri_bridge #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  dri_pkg::thr_t   thr,
    input  logic [DT_W-1:0] dead_eff,
    output logic            hs_o,
    output logic            ls_o
);
    import dri_pkg::*;

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    typedef struct packed {
        br_e             cur;
        br_e             pend;
        logic [DT_W-1:0] cnt;
    } br_st_t;

    br_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q.cur)
            BR_OFF: begin
                if (thr.lo)      st_d.cur = BR_HIGH;
                else if (thr.hi) st_d.cur = BR_LOW;
            end
            BR_HIGH: begin
                if (thr.hi) begin
                    st_d.cur  = BR_GAP;
                    st_d.pend = BR_LOW;
                    st_d.cnt  = dead_eff - ONE;
                end
            end
            BR_LOW: begin
                if (thr.lo) begin
                    st_d.cur  = BR_GAP;
                    st_d.pend = BR_HIGH;
                    st_d.cnt  = dead_eff - ONE;
                end
            end
            default: begin
                if (st_q.cnt == '0) st_d.cur = st_q.pend;
                else                st_d.cnt = st_q.cnt - ONE;
            end
        endcase
        if (clr) st_d = '{BR_OFF, BR_OFF, '0};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{BR_OFF, BR_OFF, '0};
        else     st_q <= st_d;
    end

    assign hs_o = (st_q.cur == BR_HIGH);
    assign ls_o = (st_q.cur == BR_LOW);

    // R11: the high switch never rises straight out of a low-switch cycle
    assert_hs_bbm_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_o) |-> !$past(ls_o));
    assert_ls_bbm_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_o) |-> !$past(hs_o));
endmodule

// File: rtl/dual_rail_inductor_seq.sv
module dual_rail_inductor_seq #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            out_a_low,
    input  logic            out_a_high,
    input  logic            out_b_low,
    input  logic            out_b_high,
    input  logic            b_first,
    input  logic            rev_flag,
    input  logic [DT_W-1:0] dead_cfg,
    output logic            hs_en,
    output logic            ls_en,
    output logic            sel_a_en,
    output logic            sel_b_en,
    output logic            short_en
);
    import dri_pkg::*;

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    logic [FL_N-1:0] raw_flags, syn;
    logic            stby_q;
    logic [DT_W-1:0] dead_eff;
    logic            rail_a, rail_b, br_hs, br_ls;
    thr_t            served;

    assign raw_flags = {rev_flag, b_first, out_b_high, out_b_low, out_a_high, out_a_low};

    dri_sync #(.N(FL_N)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_flags), .q_sync(syn)
    );

    // Standby follows the synchronised reverse flag; reset starts grounded
    always_ff @(posedge clk) begin
        if (rst) stby_q <= 1'b1;
        else     stby_q <= syn[FL_REV];
    end

    assign dead_eff = (dead_cfg == '0) ? ONE : dead_cfg;

    dri_arbiter #(.DT_W(DT_W)) u_arb (
        .clk(clk), .rst(rst), .clr(stby_q),
        .req_a(syn[FL_LO_A]), .req_b(syn[FL_LO_B]), .b_first(syn[FL_PRI_B]),
        .dead_eff(dead_eff), .sel_a_o(rail_a), .sel_b_o(rail_b)
    );

    // Bridge sees only the thresholds of the rail currently connected
    always_comb begin
        served = '0;
        if (rail_a) begin
            served.lo = syn[FL_LO_A];
            served.hi = syn[FL_HI_A];
        end else if (rail_b) begin
            served.lo = syn[FL_LO_B];
            served.hi = syn[FL_HI_B];
        end
    end

    dri_bridge #(.DT_W(DT_W)) u_br (
        .clk(clk), .rst(rst), .clr(stby_q), .thr(served),
        .dead_eff(dead_eff), .hs_o(br_hs), .ls_o(br_ls)
    );

    assign hs_en    = br_hs  & ~stby_q;
    assign ls_en    = br_ls  |  stby_q;
    assign sel_a_en = rail_a & ~stby_q;
    assign sel_b_en = rail_b & ~stby_q;
    assign short_en = stby_q;

    // R1: the cycle after a reset edge has the inductor grounded
    assert_reset_ground_R1: assert property (@(posedge clk)
        rst |=> (ls_en && short_en && !hs_en && !sel_a_en && !sel_b_en));

    // R4: leaving standby gives one all-off cycle from the cleared loops
    assert_resume_off_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(stby_q) |-> (!hs_en && !ls_en && !sel_a_en && !sel_b_en && !short_en));

    // R11: high and low switches never conduct together at the pins
    assert_no_shoot_R11: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));
endmodule

// File: tb/sim_dual_rail_inductor_seq.sv
module sim_dual_rail_inductor_seq;
    localparam int DT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic la = 1'b0, ha = 1'b0, lb = 1'b0, hb = 1'b0, pri = 1'b0, rev = 1'b0;
    logic [DT_W-1:0] dead_cfg = '0;
    logic hs_en, ls_en, sel_a_en, sel_b_en, short_en;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_rail_inductor_seq #(.DT_W(DT_W)) u0 (
        .clk(clk), .rst(rst),
        .out_a_low(la), .out_a_high(ha), .out_b_low(lb), .out_b_high(hb),
        .b_first(pri), .rev_flag(rev), .dead_cfg(dead_cfg),
        .hs_en(hs_en), .ls_en(ls_en), .sel_a_en(sel_a_en),
        .sel_b_en(sel_b_en), .short_en(short_en)
    );

    // order: hs, ls, sel_a, sel_b, short
    function automatic logic [4:0] outs();
        return {hs_en, ls_en, sel_a_en, sel_b_en, short_en};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        {la, ha, lb, hb, pri, rev} = '0;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    // expected rail: 0 none, 1 A, 2 B
    function automatic int exp_rail(input int start, input logic a, input logic b, input logic p);
        int want;
        if (a && b)  want = p ? 2 : 1;
        else if (a)  want = 1;
        else if (b)  want = 2;
        else         want = 0;
        return (want == 0) ? start : want;
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dd;
        @(negedge clk);
        step(2);
        check("R1 reset pattern", outs(), 5'b01001);

        foreach (dd_list[k]) begin
            int d;
            d = dd_list[k];
            dd = (d == 0) ? 1 : d;
            dead_cfg = DT_W'(d);
            do_reset();

            la = 1'b1;
            step(8 + dd);
            check("R5 rail A selected, high on", outs(), 5'b10100);

            hb = 1'b1;
            step(6);
            check("R12 idle rail B high ignored", outs(), 5'b10100);
            hb = 1'b0;

            // high -> low changeover
            la = 1'b0; ha = 1'b1;
            step(2);
            check("R2 no change before third edge", outs(), 5'b10100);
            step(1);
            for (int i = 0; i < dd; i++) begin
                check("R11 high-low gap", outs(), 5'b00100);
                step(1);
            end
            check("R10 low switch on when rail high", outs(), 5'b01100);

            // low -> high changeover
            ha = 1'b0; la = 1'b1;
            step(2);
            check("R2 low held", outs(), 5'b01100);
            step(1);
            for (int i = 0; i < dd; i++) begin
                check("R11 low-high gap", outs(), 5'b00100);
                step(1);
            end
            check("R10 high switch on when rail low", outs(), 5'b10100);

            // rail A -> rail B changeover
            la = 1'b0; lb = 1'b1;
            step(2);
            check("R2 rail A held", outs(), 5'b10100);
            step(1);
            for (int i = 0; i < dd; i++) begin
                check("R9 select gap", outs(), 5'b10000);
                step(1);
            end
            check("R6 rail B selected", outs(), 5'b10010);

            ha = 1'b1;
            step(6);
            check("R12 idle rail A high ignored", outs(), 5'b10010);
            ha = 1'b0;
        end

        // arbitration sweep
        dead_cfg = DT_W'(2);
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                int er;
                logic a, b, p;
                a = c[0]; b = c[1]; p = c[2];
                do_reset();
                if (s >= 1) begin la = 1'b1; step(10); end
                if (s == 2) begin la = 1'b0; lb = 1'b1; step(12); end
                la = a; lb = b; pri = p;
                step(12);
                er = exp_rail(s, a, b, p);
                check((a && b) ? "R7 priority pick" : ((a || b) ? "R5 R6 request" : "R8 hold"),
                      {3'b000, sel_a_en, sel_b_en},
                      {3'b000, (er == 1), (er == 2)});
            end
        end

        // reverse-current override and recovery
        dead_cfg = DT_W'(1);
        do_reset();
        la = 1'b1;
        step(10);
        check("R5 setup", outs(), 5'b10100);
        rev = 1'b1;
        step(2);
        check("R2 reverse not yet seen", outs(), 5'b10100);
        step(1);
        check("R3 standby entered", outs(), 5'b01001);
        lb = 1'b1; hb = 1'b1;
        step(5);
        check("R3 standby held", outs(), 5'b01001);
        lb = 1'b0; hb = 1'b0;
        rev = 1'b0;
        step(2);
        check("R3 standby until sync", outs(), 5'b01001);
        step(1);
        check("R4 all-off cycle", outs(), 5'b00000);
        step(1);
        check("R4 selector first", outs(), 5'b00100);
        step(1);
        check("R4 bridge next", outs(), 5'b10100);

        rst = 1'b1;
        step(2);
        check("R1 reset again", outs(), 5'b01001);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int dd_list[4] = '{0, 1, 3, 7};
endmodule